// File: doc/BRIEF.md
# Eight-Register Single-Cycle Processor Core

This block is a small processor that completes one instruction in every clock cycle. A 15-bit instruction is fetched from an internal program memory at the address held in the program counter. It is decoded and executed against a file of eight 8-bit registers, and its result is written back on the same clock edge. Each instruction carries a 4-bit opcode and one or two 3-bit register fields. The move instruction carries an 8-bit constant in place of the second field. The instruction set covers arithmetic and logic on register pairs, an unsigned greater-than test, byte load and store to an internal data memory, clearing a register, and a conditional relative branch.

The program and data memories are preloaded through dedicated write ports while reset is held. Releasing reset starts execution at address 0. Execution stops when the program counter reaches the last program address, which is signalled on a halt output. Two combinational peek ports let the environment read any register and any data byte, so results can be inspected at any time.

Top module: `tiny_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter and all eight registers become 0, so `pc_out`=0, `halt`=0 and every `peek_reg_val` reads 0 one cycle later.
- R2: Writes on the program port (`imem_wr`) and the data port (`dmem_wr`) take effect only on edges where `rst` is high. A data-port write with `rst` low leaves the addressed byte unchanged.
- R3: The instruction word is opcode[14:11], first register A[10:8], second register B[7:5]. Any executed instruction other than a taken branch advances the program counter by exactly one per cycle.
- R4: Opcode 4'b0011 writes the 8-bit constant in bits [7:0] into register A.
- R5: Opcodes 4'b0101, 4'b0110, 4'b0111 and 4'b1000 write A+B, A-B, A&B and A|B into register A, modulo 256. Register B is left unchanged.
- R6: Opcode 4'b1001 writes 1 into register A when A is greater than B as unsigned numbers, and writes 0 otherwise, including when A equals B.
- R7: Opcode 4'b0100 loads register A from the data byte addressed by register B. Opcode 4'b0010 stores register A into the data byte addressed by register B.
- R8: Opcode 4'b1100 sets the program counter to PC plus the sign-extended 5-bit offset in bits [4:0] when A > B (unsigned). Otherwise it advances by one.
- R9: Opcode 4'b1011 sets register A to 0.
- R10: Any other opcode (4'b0000, 4'b0001, 4'b1010, 4'b1101, 4'b1110, 4'b1111) changes no register and no data byte.
- R11: `halt` is high exactly when the program counter equals the last program address. The instruction stored there is never executed, and the program counter and registers stay frozen until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also the preload window |
| imem_wr | input | 1 | Program memory write strobe |
| imem_waddr | input | 5 | Program memory write address |
| imem_wdata | input | 15 | Program memory write data (instruction word) |
| dmem_wr | input | 1 | Data memory preload write strobe |
| dmem_waddr | input | 8 | Data memory preload address |
| dmem_wdata | input | 8 | Data memory preload data |
| peek_reg_sel | input | 3 | Register index to observe |
| peek_reg_val | output | 8 | Value of the selected register |
| peek_mem_addr | input | 8 | Data memory address to observe |
| peek_mem_val | output | 8 | Value of the addressed data byte |
| pc_out | output | 5 | Current program counter |
| halt | output | 1 | High while the program counter is at the last program address |

## Verification
The hardest state to reach from the ports is a backward branch that is taken several times and then falls through. The loop exit depends on a register value that the loop itself builds up, so a wrong offset sign or a wrong compare direction either never leaves the loop or leaves it too early. The bench runs a counting loop that closes with an offset of -1 and checks both the final count and an instruction placed after the loop. Separate short programs cover a taken forward skip and a not-taken branch. Unsigned ordering is pinned down by comparing 0x80 against 0x7F, and wrap-around by sums and differences that cross 0 and 255.

// File: rtl/tiny_cpu.sv
module tiny_cpu #(
  parameter int DATA_W     = 8,
  parameter int NREGS      = 8,
  parameter int IMEM_DEPTH = 32,
  parameter int DMEM_DEPTH = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          imem_wr,
  input  logic [$clog2(IMEM_DEPTH)-1:0] imem_waddr,
  input  logic [14:0]                   imem_wdata,
  input  logic                          dmem_wr,
  input  logic [$clog2(DMEM_DEPTH)-1:0] dmem_waddr,
  input  logic [DATA_W-1:0]             dmem_wdata,
  input  logic [$clog2(NREGS)-1:0]      peek_reg_sel,
  output logic [DATA_W-1:0]             peek_reg_val,
  input  logic [$clog2(DMEM_DEPTH)-1:0] peek_mem_addr,
  output logic [DATA_W-1:0]             peek_mem_val,
  output logic [$clog2(IMEM_DEPTH)-1:0] pc_out,
  output logic                          halt
);
  localparam int IAW = $clog2(IMEM_DEPTH);
  localparam int DAW = $clog2(DMEM_DEPTH);
  localparam int RAW = $clog2(NREGS);
  localparam logic [IAW-1:0] LAST_PC = IAW'(IMEM_DEPTH - 1);

  localparam logic [3:0] OP_ST  = 4'b0010;
  localparam logic [3:0] OP_MOV = 4'b0011;
  localparam logic [3:0] OP_LD  = 4'b0100;
  localparam logic [3:0] OP_ADD = 4'b0101;
  localparam logic [3:0] OP_SUB = 4'b0110;
  localparam logic [3:0] OP_AND = 4'b0111;
  localparam logic [3:0] OP_OR  = 4'b1000;
  localparam logic [3:0] OP_GT  = 4'b1001;
  localparam logic [3:0] OP_CLR = 4'b1011;
  localparam logic [3:0] OP_BR  = 4'b1100;

  logic [14:0]       rom [IMEM_DEPTH];
  logic [DATA_W-1:0] ram [DMEM_DEPTH];
  logic [DATA_W-1:0] rf  [NREGS];
  logic [IAW-1:0]    pc;

  logic [14:0]       instr;
  logic [3:0]        op;
  logic [RAW-1:0]    fa, fb;
  logic [DATA_W-1:0] a_val, b_val, imm;
  logic              ex, a_gt_b;
  logic [IAW+4:0]    off_wide;
  logic [IAW-1:0]    pc_inc, pc_next;
  logic              wr_en;
  logic [DATA_W-1:0] wr_val;

  assign instr    = rom[pc];
  assign op       = instr[14:11];
  assign fa       = instr[10:8];
  assign fb       = instr[7:5];
  assign imm      = instr[7:0];
  assign a_val    = rf[fa];
  assign b_val    = rf[fb];
  assign a_gt_b   = a_val > b_val;
  assign halt     = pc == LAST_PC;
  assign ex       = !rst && !halt;
  assign off_wide = {{IAW{instr[4]}}, instr[4:0]};
  assign pc_inc   = pc + 1'b1;
  assign pc_next  = (op == OP_BR && a_gt_b) ? pc + off_wide[IAW-1:0] : pc_inc;

  always_comb begin
    wr_en  = 1'b1;
    wr_val = '0;
    case (op)
      OP_MOV:  wr_val = imm;
      OP_LD:   wr_val = ram[b_val[DAW-1:0]];
      OP_ADD:  wr_val = a_val + b_val;
      OP_SUB:  wr_val = a_val - b_val;
      OP_AND:  wr_val = a_val & b_val;
      OP_OR:   wr_val = a_val | b_val;
      OP_GT:   wr_val = DATA_W'(a_gt_b);
      OP_CLR:  wr_val = '0;
      default: wr_en  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (!halt) begin
      pc <= pc_next;
      if (wr_en) rf[fa] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst && imem_wr) rom[imem_waddr] <= imem_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (dmem_wr) ram[dmem_waddr] <= dmem_wdata;
    end else if (ex && op == OP_ST) begin
      ram[b_val[DAW-1:0]] <= a_val;
    end
  end

  assign peek_reg_val = rf[peek_reg_sel];
  assign peek_mem_val = ram[peek_mem_addr];
  assign pc_out       = pc;

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    (ex && op != OP_BR) |=> pc == IAW'($past(pc) + 1'b1));

  assert_mov_R4: assert property (@(posedge clk) disable iff (rst)
    (ex && op == OP_MOV) |=> rf[$past(fa)] == $past(imm));

  assert_gt_bool_R6: assert property (@(posedge clk) disable iff (rst)
    (ex && op == OP_GT) |=> rf[$past(fa)] <= DATA_W'(1));

  assert_store_R7: assert property (@(posedge clk) disable iff (rst)
    (ex && op == OP_ST) |=> ram[$past(b_val[DAW-1:0])] == $past(a_val));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (ex && op == OP_CLR) |=> rf[$past(fa)] == '0);

  assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt && $stable(pc));
endmodule

// File: tb/tiny_cpu_bench.sv
module tiny_cpu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_wr = 1'b0;
  logic [4:0]  imem_waddr = '0;
  logic [14:0] imem_wdata = '0;
  logic        dmem_wr = 1'b0;
  logic [7:0]  dmem_waddr = '0;
  logic [7:0]  dmem_wdata = '0;
  logic [2:0]  peek_reg_sel = '0;
  logic [7:0]  peek_reg_val;
  logic [7:0]  peek_mem_addr = '0;
  logic [7:0]  peek_mem_val;
  logic [4:0]  pc_out;
  logic        halt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [14:0] prog [32];

  always #4 clk = ~clk;

  tiny_cpu u_tiny_cpu (
    .clk(clk), .rst(rst),
    .imem_wr(imem_wr), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .dmem_wr(dmem_wr), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
    .peek_reg_sel(peek_reg_sel), .peek_reg_val(peek_reg_val),
    .peek_mem_addr(peek_mem_addr), .peek_mem_val(peek_mem_val),
    .pc_out(pc_out), .halt(halt)
  );

  // vector: opcode, A value, B value, expected A after execution
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {4'b0101, 8'h05, 8'h07, 8'h0C},
    {4'b0101, 8'hF0, 8'h20, 8'h10},
    {4'b0110, 8'h09, 8'h03, 8'h06},
    {4'b0110, 8'h03, 8'h09, 8'hFA},
    {4'b0111, 8'hCC, 8'hAA, 8'h88},
    {4'b1000, 8'hC0, 8'h0A, 8'hCA},
    {4'b1001, 8'h80, 8'h7F, 8'h01},
    {4'b1001, 8'h01, 8'hFF, 8'h00},
    {4'b1001, 8'h42, 8'h42, 8'h00},
    {4'b0001, 8'h33, 8'h44, 8'h33},
    {4'b1010, 8'h33, 8'h44, 8'h33},
    {4'b1111, 8'h33, 8'h44, 8'h33}
  };

  function automatic logic [14:0] rr(input logic [3:0] op, input logic [2:0] a, input logic [2:0] b);
    return {op, a, b, 5'd0};
  endfunction
  function automatic logic [14:0] mv(input logic [2:0] a, input logic [7:0] k);
    return {4'b0011, a, k};
  endfunction
  function automatic logic [14:0] br(input logic [2:0] a, input logic [2:0] b, input logic [4:0] off);
    return {4'b1100, a, b, off};
  endfunction
  function automatic string tag_of(input logic [3:0] op);
    if (op == 4'b1001) return "R6";
    if (op >= 4'b0101 && op <= 4'b1000) return "R5";
    return "R10";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = 15'd0;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic poke_ram(input logic [7:0] a, input logic [7:0] d);
    dmem_wr = 1'b1; dmem_waddr = a; dmem_wdata = d;
    @(negedge clk);
    dmem_wr = 1'b0;
  endtask

  task automatic load_and_run();
    for (int i = 0; i < 32; i++) begin
      imem_wr = 1'b1; imem_waddr = 5'(i); imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_wr = 1'b0;
    rst = 1'b0;
    for (int t = 0; t < 300 && !halt; t++) @(negedge clk);
    if (!halt) chk("R11 halt reached", 32'd0, 32'd1);
  endtask

  task automatic run_prog();
    enter_reset();
    load_and_run();
  endtask

  function automatic logic [7:0] dummy(input logic [7:0] x);
    return x;
  endfunction

  task automatic reg_is(input string tag, input logic [2:0] r, input logic [7:0] exp);
    peek_reg_sel = r;
    #1;
    chk(tag, {24'd0, peek_reg_val}, {24'd0, exp});
  endtask

  task automatic mem_is(input string tag, input logic [7:0] a, input logic [7:0] exp);
    peek_mem_addr = a;
    #1;
    chk(tag, {24'd0, peek_mem_val}, {24'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 pc after reset", {27'd0, pc_out}, 32'd0);
    chk("R1 halt after reset", {31'd0, halt}, 32'd0);
    for (int r = 0; r < 8; r++) reg_is("R1 register after reset", 3'(r), 8'h00);

    // R5 R6 R10: table of ALU vectors, operands in R5 (A) and R3 (B)
    for (int v = 0; v < NV; v++) begin
      clear_prog();
      prog[0] = mv(3'd5, VEC[v][23:16]);
      prog[1] = mv(3'd3, VEC[v][15:8]);
      prog[2] = rr(VEC[v][27:24], 3'd5, 3'd3);
      run_prog();
      reg_is(tag_of(VEC[v][27:24]), 3'd5, VEC[v][7:0]);
      reg_is({tag_of(VEC[v][27:24]), " B unchanged"}, 3'd3, VEC[v][15:8]);
    end

    // R4 move immediate and R3 sequencing / R11 halt address
    clear_prog();
    prog[0] = mv(3'd7, 8'h0C);
    prog[1] = mv(3'd0, 8'hFF);
    prog[31] = mv(3'd6, 8'h77);
    run_prog();
    reg_is("R4 mov R7", 3'd7, 8'h0C);
    reg_is("R4 mov R0", 3'd0, 8'hFF);
    reg_is("R11 last instruction not executed", 3'd6, 8'h00);
    chk("R11 pc at last", {27'd0, pc_out}, 32'd31);
    chk("R3 halt when pc last", {31'd0, halt}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R11 pc frozen", {27'd0, pc_out}, 32'd31);

    // R3: pc advances one per cycle
    enter_reset();
    clear_prog();
    for (int i = 0; i < 32; i++) begin
      imem_wr = 1'b1; imem_waddr = 5'(i); imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_wr = 1'b0;
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 pc after five cycles", {27'd0, pc_out}, 32'd5);
    repeat (40) @(negedge clk);

    // R7 load/store, R2 preload window
    enter_reset();
    poke_ram(8'h80, 8'h37);
    poke_ram(8'h90, 8'h12);
    clear_prog();
    prog[0] = mv(3'd1, 8'h40);
    prog[1] = mv(3'd2, 8'h5A);
    prog[2] = rr(4'b0010, 3'd2, 3'd1);
    prog[3] = rr(4'b0100, 3'd3, 3'd1);
    prog[4] = mv(3'd5, 8'h80);
    prog[5] = rr(4'b0100, 3'd4, 3'd5);
    load_and_run();
    mem_is("R7 store writes byte", 8'h40, 8'h5A);
    reg_is("R7 load stored byte", 3'd3, 8'h5A);
    reg_is("R7 load preloaded byte", 3'd4, 8'h37);
    mem_is("R2 preload accepted in reset", 8'h90, 8'h12);
    dmem_wr = 1'b1; dmem_waddr = 8'h90; dmem_wdata = 8'hFF;
    @(negedge clk);
    dmem_wr = 1'b0;
    mem_is("R2 write outside reset ignored", 8'h90, 8'h12);

    // R1: reset mid-state clears registers
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    reg_is("R1 reset clears loaded reg", 3'd3, 8'h00);
    chk("R1 reset clears pc", {27'd0, pc_out}, 32'd0);

    // R9 clear
    clear_prog();
    prog[0] = mv(3'd2, 8'h33);
    prog[1] = mv(3'd4, 8'h44);
    prog[2] = {4'b1011, 3'd2, 8'd0};
    run_prog();
    reg_is("R9 cleared register", 3'd2, 8'h00);
    reg_is("R9 other register kept", 3'd4, 8'h44);

    // R10: unused opcode must not touch data memory
    enter_reset();
    poke_ram(8'h07, 8'h21);
    clear_prog();
    prog[0] = mv(3'd1, 8'h07);
    prog[1] = mv(3'd2, 8'hEE);
    prog[2] = rr(4'b1101, 3'd2, 3'd1);
    prog[3] = rr(4'b1110, 3'd2, 3'd1);
    prog[4] = rr(4'b0000, 3'd2, 3'd1);
    load_and_run();
    mem_is("R10 unused opcode leaves memory", 8'h07, 8'h21);
    reg_is("R10 unused opcode leaves register", 3'd2, 8'hEE);

    // R8 backward loop: count R1 up to 5
    clear_prog();
    prog[0] = mv(3'd1, 8'h00);
    prog[1] = mv(3'd2, 8'h01);
    prog[2] = mv(3'd3, 8'h05);
    prog[3] = rr(4'b0101, 3'd1, 3'd2);
    prog[4] = br(3'd3, 3'd1, 5'b11111);
    prog[5] = mv(3'd4, 8'hAA);
    run_prog();
    reg_is("R8 backward loop count", 3'd1, 8'h05);
    reg_is("R8 fall through after loop", 3'd4, 8'hAA);

    // R8 forward taken skip
    clear_prog();
    prog[0] = mv(3'd1, 8'h09);
    prog[1] = mv(3'd2, 8'h03);
    prog[2] = br(3'd1, 3'd2, 5'd2);
    prog[3] = mv(3'd5, 8'h11);
    prog[4] = mv(3'd6, 8'h22);
    run_prog();
    reg_is("R8 taken branch skips", 3'd5, 8'h00);
    reg_is("R8 taken branch target runs", 3'd6, 8'h22);

    // R8 not taken
    prog[2] = br(3'd2, 3'd1, 5'd2);
    run_prog();
    reg_is("R8 not taken executes next", 3'd5, 8'h11);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule